// File: doc/BRIEF.md
# Direct-Mapped Blocking Write-Back Data Cache

This block is a data cache placed between a processor and a word-wide memory port. It holds `LINES` lines of `WORDS` 32-bit words. Each line has its own tag and a three-valued status: invalid, clean or dirty. The processor sends loads, stores and line flushes. Load results come back in request order through a response port that the processor pops explicitly. A hit is answered in the same cycle as the request.

The cache is blocking. A miss stops the request port until the miss is resolved. If the victim line is dirty, it is first sent word by word to memory as stores. The missing line is then requested word by word and installed as clean once its last word arrives. The original request is then replayed as a hit. A store updates only the word it addresses and marks the line dirty. A flush writes a dirty line back and then invalidates it.

Byte addresses are 32 bits wide. From the least significant end, an address holds two byte-offset bits, then the word-in-line bits, then the line index, and the tag in the remaining upper bits.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and `resp_valid` and `mreq_valid` are 0. The first access to any line therefore misses.
- R2: A load that hits raises `resp_valid` with the addressed word in the same cycle as the request is offered, with no memory traffic.
- R3: A load miss on a clean or invalid line issues `WORDS` memory loads (`mreq_op`=0), one per word of the line, in ascending address order from the line base. The loaded word is returned after the last fill response. `req_ready` stays 0 while memory requests are outstanding.
- R4: A store that hits (`req_op`=2'b01) writes only its addressed word, marks the line dirty, produces no response and causes no memory traffic.
- R5: A miss whose victim line is dirty first issues `WORDS` memory stores (`mreq_op`=1) of the victim's words. Their addresses are built from the victim tag and index, in ascending order. The fill loads follow. No memory request is issued while fill responses are being awaited.
- R6: A miss whose victim line is clean issues no memory store.
- R7: A store miss fills the line from memory and then writes its word. A later load of another word of that line returns the memory value.
- R8: A flush (`req_op`=2'b1x) of a present dirty line writes it back with `WORDS` stores and invalidates it. A flush of a present clean line invalidates it with no memory traffic. A flush of an address whose line is not present has no effect.
- R9: A load response is held, with stable data, until `resp_deq` is 1. While it is held, `req_ready` is 0, so responses leave in request order.
- R10: A memory request held with `mreq_ready`=0 keeps its op, address and write data stable until it is taken.
- R11: Request op encodings are 2'b00 load, 2'b01 store and 2'b10 or 2'b11 flush. Every load returns the last value stored to its address, or the memory value if none was stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_op | input | 2 | 00 load, 01 store, 1x flush |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Load result at the response head |
| resp_data | output | 32 | Load result |
| resp_deq | input | 1 | Pop the load result |
| mreq_valid | output | 1 | Memory request present |
| mreq_ready | input | 1 | Memory takes the request |
| mreq_op | output | 1 | 0 load, 1 store |
| mreq_addr | output | 32 | Word-aligned memory byte address |
| mreq_wdata | output | 32 | Write-back data |
| mresp_valid | input | 1 | Fill word present |
| mresp_ready | output | 1 | Cache accepts a fill word |
| mresp_data | input | 32 | Fill word |

## Verification
A load hit is due in the very cycle it is offered. The bench therefore samples `resp_valid` 1 ns after driving the request at the falling edge, before the accepting rising edge. A zero-latency result is recorded only when it appears there. Miss results may arrive any number of cycles later, because the memory model randomises both `mreq_ready` and the fill delay. The bench therefore polls `resp_valid` at each falling edge and checks the data only, never a fixed latency. Memory traffic is logged at rising edges and compared against the exact expected store/load sequence for each scenario once the cache is idle again, that is, with `req_ready` high and no memory request.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int LINES = 256,
  parameter int WORDS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        resp_valid,
  output logic [31:0] resp_data,
  input  logic        resp_deq,
  output logic        mreq_valid,
  input  logic        mreq_ready,
  output logic        mreq_op,
  output logic [31:0] mreq_addr,
  output logic [31:0] mreq_wdata,
  input  logic        mresp_valid,
  output logic        mresp_ready,
  input  logic [31:0] mresp_data
);

  localparam int WOB = $clog2(WORDS);
  localparam int IXB = $clog2(LINES);
  localparam int TGW = 32 - 2 - WOB - IXB;
  localparam int BW  = (WOB > 0) ? WOB : 1;
  localparam int EW  = IXB + WOB;
  localparam int ENT = LINES * WORDS;
  localparam logic [1:0] L_INV = 2'd0, L_CLN = 2'd1, L_DRT = 2'd2;

  typedef enum logic [2:0] {S_RDY, S_WB, S_FREQ, S_FRSP, S_FHIT} st_t;

  st_t              st_q;
  logic [1:0]       lst_q  [LINES];
  logic [TGW-1:0]   tag_q  [LINES];
  logic [31:0]      data_q [ENT];
  logic [BW-1:0]    beat_q;
  logic [1:0]       miss_op;
  logic [31:0]      miss_addr, miss_wdata;
  logic             hq_full;
  logic             hq_store;
  logic [31:0]      hq_addr, hq_wdata;

  logic [IXB-1:0]   r_idx, m_idx;
  logic [TGW-1:0]   r_tag, m_tag;
  logic             r_match, fire, r_flush;
  logic             acc_hit, acc_miss, fl_dirty, fl_clean;
  logic             h_valid, h_store, h_pop;
  logic [31:0]      h_addr, h_wdata;
  logic             last_beat;
  logic [EW-1:0]    m_ent;
  logic [31:0]      beat_off;
  logic             unused_bits;

  assign r_idx   = req_addr[2+WOB +: IXB];
  assign r_tag   = req_addr[31 -: TGW];
  assign m_idx   = miss_addr[2+WOB +: IXB];
  assign m_tag   = miss_addr[31 -: TGW];
  assign r_match = (lst_q[r_idx] != L_INV) && (tag_q[r_idx] == r_tag);

  assign req_ready = (st_q == S_RDY) && !hq_full;
  assign fire      = req_valid && req_ready;
  assign r_flush   = req_op[1];
  assign acc_hit   = fire && !r_flush && r_match;
  assign acc_miss  = fire && !r_flush && !r_match;
  assign fl_dirty  = fire && r_flush && r_match && (lst_q[r_idx] == L_DRT);
  assign fl_clean  = fire && r_flush && r_match && (lst_q[r_idx] == L_CLN);

  always_comb begin
    h_valid = 1'b0;
    h_store = 1'b0;
    h_addr  = req_addr;
    h_wdata = req_wdata;
    if (hq_full) begin
      h_valid = 1'b1;
      h_store = hq_store;
      h_addr  = hq_addr;
      h_wdata = hq_wdata;
    end else if (acc_hit) begin
      h_valid = 1'b1;
      h_store = req_op[0];
    end else if (st_q == S_FHIT) begin
      h_valid = 1'b1;
      h_store = miss_op[0];
      h_addr  = miss_addr;
      h_wdata = miss_wdata;
    end
  end

  assign resp_valid = h_valid && !h_store;
  assign resp_data  = data_q[h_addr[2 +: EW]];
  assign h_pop      = h_valid && (h_store || resp_deq);

  assign last_beat = (beat_q == BW'(WORDS - 1));
  assign m_ent     = EW'(EW'(m_idx) * EW'(WORDS) + EW'(beat_q));
  assign beat_off  = (WOB > 0) ? (32'(beat_q) << 2) : 32'd0;

  assign mreq_valid  = (st_q == S_WB) || (st_q == S_FREQ);
  assign mreq_op     = (st_q == S_WB);
  assign mreq_addr   = ((st_q == S_WB) ? (32'(tag_q[m_idx]) << (2 + WOB + IXB))
                                       : (32'(m_tag) << (2 + WOB + IXB)))
                     | (32'(m_idx) << (2 + WOB)) | beat_off;
  assign mreq_wdata  = data_q[m_ent];
  assign mresp_ready = (st_q == S_FRSP);

  assign unused_bits = ^{req_addr[1:0], miss_addr[1:0], h_addr, h_wdata[0], mreq_addr[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_RDY;
      beat_q     <= '0;
      miss_op    <= 2'b00;
      miss_addr  <= '0;
      miss_wdata <= '0;
      hq_full    <= 1'b0;
      hq_store   <= 1'b0;
      hq_addr    <= '0;
      hq_wdata   <= '0;
    end else begin
      if (hq_full && h_pop)
        hq_full <= 1'b0;
      else if (!hq_full && h_valid && !h_pop) begin
        hq_full  <= 1'b1;
        hq_store <= h_store;
        hq_addr  <= h_addr;
        hq_wdata <= h_wdata;
      end
      case (st_q)
        S_RDY: begin
          if (acc_miss || fl_dirty) begin
            miss_op    <= req_op;
            miss_addr  <= req_addr;
            miss_wdata <= req_wdata;
            beat_q     <= '0;
            st_q       <= (fl_dirty || lst_q[r_idx] == L_DRT) ? S_WB : S_FREQ;
          end
        end
        S_WB: begin
          if (mreq_ready) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
            if (last_beat) st_q <= miss_op[1] ? S_RDY : S_FREQ;
          end
        end
        S_FREQ: begin
          if (mreq_ready) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
            if (last_beat) st_q <= S_FRSP;
          end
        end
        S_FRSP: begin
          if (mresp_valid) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
            if (last_beat) st_q <= S_FHIT;
          end
        end
        default: st_q <= S_RDY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_FRSP && mresp_valid)
      data_q[m_ent] <= mresp_data;
    else if (h_valid && h_store)
      data_q[h_addr[2 +: EW]] <= h_wdata;
    if (st_q == S_FRSP && mresp_valid && last_beat)
      tag_q[m_idx] <= m_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) lst_q[i] <= L_INV;
    end else begin
      if (fl_clean)
        lst_q[r_idx] <= L_INV;
      if (st_q == S_WB && mreq_ready && last_beat && miss_op[1])
        lst_q[m_idx] <= L_INV;
      if (st_q == S_FRSP && mresp_valid && last_beat)
        lst_q[m_idx] <= L_CLN;
      if (h_valid && h_store)
        lst_q[h_addr[2+WOB +: IXB]] <= L_DRT;
    end
  end

endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        resp_valid,
  input logic [31:0] resp_data,
  input logic        resp_deq,
  input logic        mreq_valid,
  input logic        mreq_ready,
  input logic        mreq_op,
  input logic [31:0] mreq_addr,
  input logic [31:0] mreq_wdata,
  input logic        mresp_ready
);

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_op) && $stable(mreq_addr) && $stable(mreq_wdata)); // R10

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_deq |=> resp_valid && $stable(resp_data)); // R9

  AST_BLOCK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_deq |=> !req_ready); // R9

  AST_BUSY_DURING_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> !req_ready); // R3

  AST_FILL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mresp_ready |-> !mreq_valid); // R5

endmodule

bind dm_wb_cache dm_wb_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_data(resp_data), .resp_deq(resp_deq), .mreq_valid(mreq_valid),
  .mreq_ready(mreq_ready), .mreq_op(mreq_op), .mreq_addr(mreq_addr),
  .mreq_wdata(mreq_wdata), .mresp_ready(mresp_ready)
);

// File: tb/dm_wb_cache_test.sv
`timescale 1ns/1ps
module dm_wb_cache_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, resp_deq = 0, mreq_ready = 0, mresp_valid = 0;
  logic [1:0] req_op = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, mresp_data = 0;
  logic req_ready, resp_valid, mreq_valid, mreq_op, mresp_ready;
  logic [31:0] resp_data, mreq_addr, mreq_wdata;

  always #4 clk = ~clk;

  dm_wb_cache #(.LINES(4), .WORDS(2)) uut (.*);

  int n_chk = 0, n_fail = 0, hold_err = 0;
  logic [31:0] bmem [64];
  logic [31:0] refm [64];
  logic [31:0] mq [16];
  int mq_h = 0, mq_t = 0;
  logic        lg_op [256];
  logic [31:0] lg_addr [256];
  int lg_n = 0;
  logic pend = 0;
  logic [31:0] pend_addr = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        if (pend && (!mreq_valid || mreq_addr != pend_addr)) hold_err++;
        pend = mreq_valid && !mreq_ready;
        pend_addr = mreq_addr;
        if (mreq_valid && mreq_ready) begin
          lg_op[lg_n % 256] = mreq_op;
          lg_addr[lg_n % 256] = mreq_addr;
          lg_n++;
          if (mreq_op) bmem[mreq_addr[7:2]] = mreq_wdata;
          else begin mq[mq_t % 16] = mreq_addr; mq_t++; end
        end
        if (mresp_valid && mresp_ready) mq_h++;
      end
      @(negedge clk);
      mreq_ready  = ($urandom % 4) != 0;
      mresp_valid = (mq_t != mq_h) && (($urandom % 3) != 0);
      mresp_data  = (mq_t != mq_h) ? bmem[mq[mq_h % 16][7:2]] : 32'd0;
    end
  end

  task automatic wait_idle();
    @(negedge clk); #1;
    while (!(req_ready && !mreq_valid)) begin @(negedge clk); #1; end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                       output int lat, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    lat = -1; rd = 0;
    if (op == 2'b00 && resp_valid) begin lat = 0; rd = resp_data; resp_deq = 1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; resp_deq = 0;
    if (op == 2'b00 && lat < 0) begin
      lat = 1; #1;
      while (!resp_valid) begin @(negedge clk); #1; lat++; end
      rd = resp_data; resp_deq = 1;
      @(negedge clk); resp_deq = 0;
    end
  endtask

  task automatic log_is(input int idx, input logic op, input logic [31:0] a, input string r);
    chk(lg_op[idx] == op && lg_addr[idx] == a, r, {lg_op[idx], lg_addr[idx][30:0]}, {op, a[30:0]});
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] rd;
    for (int i = 0; i < 64; i++) begin bmem[i] = 32'hA500_0000 + i * 32'h1111; refm[i] = bmem[i]; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(req_ready == 1 && resp_valid == 0 && mreq_valid == 0, "R1 reset outputs",
        {req_ready, resp_valid, mreq_valid}, 3'b100);

    lg_n = 0;
    issue(2'b00, 32'h00, 0, lat, rd);
    chk(rd == refm[0], "R3 load miss data", rd, refm[0]);
    wait_idle();
    chk(lg_n == 2, "R1 first access misses", lg_n, 2);
    log_is(0, 0, 32'h00, "R3 fill word 0");
    log_is(1, 0, 32'h04, "R3 fill word 1");

    lg_n = 0;
    issue(2'b00, 32'h04, 0, lat, rd);
    chk(lat == 0, "R2 hit zero latency", lat, 0);
    chk(rd == refm[1], "R2 hit data", rd, refm[1]);
    chk(lg_n == 0, "R2 no traffic", lg_n, 0);

    issue(2'b01, 32'h04, 32'hDEAD_0001, lat, rd); refm[1] = 32'hDEAD_0001;
    wait_idle();
    chk(lg_n == 0, "R4 store hit no traffic", lg_n, 0);
    issue(2'b00, 32'h00, 0, lat, rd);
    chk(rd == refm[0] && lat == 0, "R4 other word untouched", rd, refm[0]);
    issue(2'b00, 32'h04, 0, lat, rd);
    chk(rd == 32'hDEAD_0001 && lat == 0, "R4 stored word", rd, 32'hDEAD_0001);

    lg_n = 0;
    issue(2'b00, 32'h20, 0, lat, rd);
    chk(rd == refm[8], "R5 load after eviction", rd, refm[8]);
    wait_idle();
    chk(lg_n == 4, "R5 traffic count", lg_n, 4);
    log_is(0, 1, 32'h00, "R5 writeback word 0");
    log_is(1, 1, 32'h04, "R5 writeback word 1");
    log_is(2, 0, 32'h20, "R5 fill word 0");
    log_is(3, 0, 32'h24, "R5 fill word 1");
    chk(bmem[1] == 32'hDEAD_0001, "R5 memory updated", bmem[1], 32'hDEAD_0001);

    lg_n = 0;
    issue(2'b00, 32'h44, 0, lat, rd);
    chk(rd == refm[17], "R6 clean victim data", rd, refm[17]);
    wait_idle();
    chk(lg_n == 2 && lg_op[0] == 0 && lg_op[1] == 0, "R6 no writeback", lg_n, 2);

    lg_n = 0;
    issue(2'b01, 32'h08, 32'hBEEF_0002, lat, rd); refm[2] = 32'hBEEF_0002;
    wait_idle();
    chk(lg_n == 2, "R7 store miss fill count", lg_n, 2);
    log_is(0, 0, 32'h08, "R7 fill word 0");
    log_is(1, 0, 32'h0C, "R7 fill word 1");
    issue(2'b00, 32'h08, 0, lat, rd);
    chk(rd == 32'hBEEF_0002 && lat == 0, "R7 stored word", rd, 32'hBEEF_0002);
    issue(2'b00, 32'h0C, 0, lat, rd);
    chk(rd == refm[3], "R7 neighbour from memory", rd, refm[3]);

    lg_n = 0;
    issue(2'b10, 32'h08, 0, lat, rd);
    wait_idle();
    chk(lg_n == 2, "R8 dirty flush count", lg_n, 2);
    log_is(0, 1, 32'h08, "R8 flush word 0");
    log_is(1, 1, 32'h0C, "R8 flush word 1");
    lg_n = 0;
    issue(2'b00, 32'h08, 0, lat, rd);
    wait_idle();
    chk(rd == 32'hBEEF_0002 && lg_n == 2, "R8 refetch after flush", rd, 32'hBEEF_0002);

    lg_n = 0;
    issue(2'b11, 32'h08, 0, lat, rd);
    wait_idle();
    chk(lg_n == 0, "R8 clean flush no traffic", lg_n, 0);
    issue(2'b00, 32'h08, 0, lat, rd);
    wait_idle();
    chk(lg_n == 2 && lat > 0, "R8 clean flush invalidates", lg_n, 2);

    lg_n = 0;
    issue(2'b10, 32'h28, 0, lat, rd);
    issue(2'b00, 32'h08, 0, lat, rd);
    chk(lat == 0 && lg_n == 0, "R8 absent flush no effect", lat, 0);

    @(negedge clk);
    req_valid = 1; req_op = 2'b00; req_addr = 32'h0C; #1;
    @(negedge clk); req_valid = 0; #1;
    for (int k = 0; k < 3; k++) begin
      chk(resp_valid == 1 && resp_data == refm[3] && req_ready == 0, "R9 response held",
          resp_data, refm[3]);
      @(negedge clk); #1;
    end
    resp_deq = 1;
    @(negedge clk); resp_deq = 0; #1;
    chk(resp_valid == 0 && req_ready == 1, "R9 released", {resp_valid, req_ready}, 2'b01);

    for (int n = 0; n < 500; n++) begin
      int w;
      int sel;
      logic [31:0] v;
      w = $urandom % 64;
      sel = $urandom % 8;
      v = $urandom;
      if (sel < 3) begin issue(2'b01, 32'(w) << 2, v, lat, rd); refm[w] = v; end
      else if (sel == 3) issue(2'b10, 32'(w) << 2, 0, lat, rd);
      else begin
        issue(2'b00, 32'(w) << 2, 0, lat, rd);
        chk(rd == refm[w], "R11 sweep load", rd, refm[w]);
      end
    end
    for (int i = 0; i < 32; i++) issue(2'b10, 32'(i) << 3, 0, lat, rd);
    wait_idle();
    for (int i = 0; i < 64; i++) chk(bmem[i] == refm[i], "R8 memory after full flush", bmem[i], refm[i]);
    chk(hold_err == 0, "R10 request stable while stalled", hold_err, 0);

    summary();
    $finish;
  end
endmodule